// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block sits between a PWM modulator and the two gate drivers of a synchronous buck power stage. It takes a decoded three-level PWM command and produces the high-side and low-side gate enables. It makes sure the two switches are never commanded on together and inserts a fixed dead time whenever conduction passes from one switch to the other. Every timing figure is a count of reference clock cycles. The defaults assume a 1 ns reference clock: 20 cycles of dead time, 18 cycles from a falling command to the high-side gate turning off, and 25 cycles from a rising command to the low-side gate turning off.

Beyond the usual complementary behaviour, a mid-level (tri-state) command parks the stage with the low-side switch on. An active-low skip select turns on diode emulation: while the command is low, a zero-current flag from the analog comparator turns the low-side gate off. It stays off until the next high command. A disable input and a fault input, which is the already-latched result of the over-current and over-temperature detectors, drop both gates at once. All inputs are plain level signals sampled on the reference clock. There is no data stream and no handshake. The sampling edge of a change is called edge 0 below.

Top module: `hb_gate_seq`

## Requirements
- R1: While reset is asserted both gates are low. After reset the first gate turn-on happens at edge DEAD_CYC, counted from the first sampling edge that sees a turn-on request.
- R2: With `drv_en` low both gates are low from the cycle after it is sampled low, whatever the level, skip and zero-current inputs are.
- R3: With `fault_lat` high both gates are low from the next cycle. After the fault clears, a gate turns on at edge DEAD_CYC.
- R4: The level input encodes 2'b00 as low, 2'b01 as high, and 2'b10 or 2'b11 as mid. In steady state a high level gives gate_hi=1, gate_lo=0, and a low level in forced-PWM mode gives gate_hi=0, gate_lo=1.
- R5: gate_hi and gate_lo are never both high in the same cycle.
- R6: When a high-side conduction ends, gate_hi falls at edge HI_OFF_CYC and gate_lo rises at edge HI_OFF_CYC+DEAD_CYC.
- R7: When a low-side conduction ends because of a high command, gate_lo falls at edge LO_OFF_CYC and gate_hi rises at edge LO_OFF_CYC+DEAD_CYC.
- R8: A mid level gives gate_lo=1 and gate_hi=0 in steady state, with the zero-current flag and the skip select having no effect.
- R9: With `skip_n` low, a low level and `zc_det` high, gate_lo is low from the next cycle.
- R10: Once zero current has cut the low-side gate, it stays off for later low commands even after `zc_det` drops. A mid level turns it on while present but does not clear the cut. Only a high command, a disable or a fault clears it.
- R11: With `skip_n` high, `zc_det` has no effect and gate_lo stays on through a low command.
- R12: A command that returns to the conducting level before the turn-off delay expires leaves that gate on without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one cycle is one timing unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Enable; low forces both gates off |
| fault_lat | input | 1 | Latched protection fault; high forces both gates off |
| skip_n | input | 1 | Low selects diode emulation; high selects forced PWM |
| zc_det | input | 1 | Zero inductor current detected |
| pwm_lvl | input | 2 | Decoded command: 00 low, 01 high, 1x mid |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
The bench sweeps every combination of enable, fault, skip select, all four level codes and the zero-current flag from a common starting point, and checks the settled gate pair. This catches a mid level that obeys the zero-current flag, or a forced-PWM stage that still cuts the low side. Directed sequences count edges on both transition directions: an off-by-one delay or a missing dead interval shows up as a gate edge one cycle early or late. Further cases cover the sticky cut, a short low glitch that must not drop the high-side gate, and turn-on after a fault or disable. A design that reused a stale cut after a mid level, or that turned on straight after a fault, would show a gate in the wrong state at a sampled edge.

// File: rtl/hb_gate_pkg.sv
`timescale 1ns/1ps
package hb_gate_pkg;

  // Conduction target requested by the command decoder
  typedef enum logic [1:0] {
    TGT_OFF = 2'd0,
    TGT_HI  = 2'd1,
    TGT_LO  = 2'd2
  } tgt_e;

  // Sequencer states
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_HI      = 3'd1,
    ST_HI_HOLD = 3'd2,
    ST_LO      = 3'd3,
    ST_LO_HOLD = 3'd4,
    ST_DEAD    = 3'd5
  } seq_st_e;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_HIGH = 2'b01;

endpackage

// File: rtl/hb_cmd_decode.sv
`timescale 1ns/1ps
module hb_cmd_decode
  import hb_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drv_en,
  input  logic       fault_lat,
  input  logic       skip_n,
  input  logic       zc_det,
  input  logic [1:0] pwm_lvl,
  output tgt_e       tgt,
  output logic       force_off
);

  logic is_low, is_high, is_mid;
  logic cut_q, cut_now;

  always_comb begin
    is_low    = (pwm_lvl == LVL_LOW);
    is_high   = (pwm_lvl == LVL_HIGH);
    is_mid    = pwm_lvl[1];
    force_off = !drv_en || fault_lat;
    // diode emulation cut applies only to a low command in skip mode
    cut_now   = !skip_n && is_low && (cut_q || zc_det);
  end

  always_comb begin
    if (force_off)    tgt = TGT_OFF;
    else if (is_high) tgt = TGT_HI;
    else if (is_mid)  tgt = TGT_LO;
    else if (cut_now) tgt = TGT_OFF;
    else              tgt = TGT_LO;
  end

  // Sticky cut: set by zero current during a skip-mode low phase,
  // cleared only by a high command or by a forced shutdown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cut_q <= 1'b0;
    else if (force_off || is_high)      cut_q <= 1'b0;
    else if (is_low && !skip_n && zc_det) cut_q <= 1'b1;
  end

  // R10: a held cut keeps the low-side request away during a low command
  a_r10_cut_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_q && is_low && !skip_n && !force_off) |-> (tgt == TGT_OFF));

  // R8: a mid level always asks for low-side conduction when running
  a_r8_mid_requests_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mid && !force_off) |-> (tgt == TGT_LO));

endmodule

// File: rtl/hb_dead_seq.sv
`timescale 1ns/1ps
module hb_dead_seq
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC   = 20,
  parameter int HI_OFF_CYC = 18,
  parameter int LO_OFF_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  tgt_e tgt,
  input  logic force_off,
  output logic gate_hi,
  output logic gate_lo
);

  localparam int MAX_A = (DEAD_CYC > HI_OFF_CYC) ? DEAD_CYC : HI_OFF_CYC;
  localparam int MAX_D = (MAX_A > LO_OFF_CYC) ? MAX_A : LO_OFF_CYC;
  localparam int CW    = $clog2(MAX_D + 1);
  localparam logic [CW-1:0] DT_LD = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] HI_LD = CW'(HI_OFF_CYC - 1);
  localparam logic [CW-1:0] LO_LD = CW'(LO_OFF_CYC - 1);

  seq_st_e       st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          cnt_zero;
  logic [CW-1:0] cnt_dec;
  logic          gh_n, gl_n;

  always_comb begin
    cnt_zero = (cnt == '0);
    cnt_dec  = cnt_zero ? '0 : cnt - 1'b1;
  end

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    unique case (st)
      ST_OFF: begin
        if (!force_off && tgt != TGT_OFF) begin
          st_n  = ST_DEAD;
          cnt_n = DT_LD;
        end
      end
      ST_HI: begin
        if (force_off) st_n = ST_OFF;
        else if (tgt != TGT_HI) begin
          st_n  = ST_HI_HOLD;
          cnt_n = HI_LD;
        end
      end
      ST_HI_HOLD: begin
        if (force_off)          st_n = ST_OFF;
        else if (tgt == TGT_HI) st_n = ST_HI;
        else if (cnt_zero) begin
          st_n  = ST_DEAD;
          cnt_n = DT_LD;
        end else cnt_n = cnt_dec;
      end
      ST_LO: begin
        if (force_off || tgt == TGT_OFF) st_n = ST_OFF;
        else if (tgt == TGT_HI) begin
          st_n  = ST_LO_HOLD;
          cnt_n = LO_LD;
        end
      end
      ST_LO_HOLD: begin
        if (force_off || tgt == TGT_OFF) st_n = ST_OFF;
        else if (tgt == TGT_LO)          st_n = ST_LO;
        else if (cnt_zero) begin
          st_n  = ST_DEAD;
          cnt_n = DT_LD;
        end else cnt_n = cnt_dec;
      end
      ST_DEAD: begin
        if (force_off) st_n = ST_OFF;
        else if (cnt_zero) begin
          case (tgt)
            TGT_HI:  st_n = ST_HI;
            TGT_LO:  st_n = ST_LO;
            default: st_n = ST_OFF;
          endcase
        end else cnt_n = cnt_dec;
      end
      default: st_n = ST_OFF;
    endcase
  end

  always_comb begin
    gh_n = (st_n == ST_HI) || (st_n == ST_HI_HOLD);
    gl_n = (st_n == ST_LO) || (st_n == ST_LO_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      cnt     <= '0;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      gate_hi <= gh_n;
      gate_lo <= gl_n;
    end
  end

  // Checker: run length of cycles with both gates off
  localparam int RW = $clog2(DEAD_CYC + 2) + 1;
  logic [RW-1:0] off_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    off_run <= '0;
    else if (gate_hi || gate_lo)   off_run <= '0;
    else if (off_run != {RW{1'b1}}) off_run <= off_run + 1'b1;
  end

  // R5: no shoot-through
  a_r5_never_both_on: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R6: low side turns on only after a full dead interval
  a_r6_dead_before_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> (off_run >= RW'(DEAD_CYC)));

  // R7: high side turns on only after a full dead interval
  a_r7_dead_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> (off_run >= RW'(DEAD_CYC)));

endmodule

// File: rtl/hb_gate_seq.sv
`timescale 1ns/1ps
module hb_gate_seq
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC   = 20,
  parameter int HI_OFF_CYC = 18,
  parameter int LO_OFF_CYC = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drv_en,
  input  logic       fault_lat,
  input  logic       skip_n,
  input  logic       zc_det,
  input  logic [1:0] pwm_lvl,
  output logic       gate_hi,
  output logic       gate_lo
);

  tgt_e tgt;
  logic force_off;

  hb_cmd_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_en    (drv_en),
    .fault_lat (fault_lat),
    .skip_n    (skip_n),
    .zc_det    (zc_det),
    .pwm_lvl   (pwm_lvl),
    .tgt       (tgt),
    .force_off (force_off)
  );

  hb_dead_seq #(
    .DEAD_CYC   (DEAD_CYC),
    .HI_OFF_CYC (HI_OFF_CYC),
    .LO_OFF_CYC (LO_OFF_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt       (tgt),
    .force_off (force_off),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo)
  );

  // R2 / R3: disable or fault drops both gates on the next cycle
  a_r2_r3_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en || fault_lat) |=> (!gate_hi && !gate_lo));

  // R9: zero current in a skip-mode low phase cuts the low side next cycle
  a_r9_zc_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !fault_lat && skip_n == 1'b0 && pwm_lvl == LVL_LOW && zc_det)
      |=> !gate_lo);

  // R11: in forced-PWM mode a running low-side gate stays on through a low command
  a_r11_forced_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_lo && drv_en && !fault_lat && skip_n && pwm_lvl == LVL_LOW) |=> gate_lo);

endmodule

// File: tb/hb_gate_seq_tb_top.sv
`timescale 1ns/1ps
module hb_gate_seq_tb_top;

  localparam int DT  = 4;
  localparam int HOF = 3;
  localparam int LOF = 5;
  localparam int SETTLE = HOF + LOF + 2*DT + 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       drv_en, fault_lat, skip_n, zc_det;
  logic [1:0] pwm_lvl;
  logic       gate_hi, gate_lo;

  int vectors = 0;
  int miscompares = 0;
  int overlap_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hb_gate_seq #(.DEAD_CYC(DT), .HI_OFF_CYC(HOF), .LO_OFF_CYC(LOF)) dut_i (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .fault_lat(fault_lat),
    .skip_n(skip_n), .zc_det(zc_det), .pwm_lvl(pwm_lvl),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always @(negedge clk) if (rst_n === 1'b1 && gate_hi && gate_lo) overlap_seen++;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic eh, input logic el);
    vectors++;
    if (gate_hi !== eh || gate_lo !== el) begin
      miscompares++;
      $display("FAIL %s: got hi=%0b lo=%0b, expected hi=%0b lo=%0b",
               req, gate_hi, gate_lo, eh, el);
    end
  endtask

  task automatic settle_hi();
    drv_en = 1; fault_lat = 0; skip_n = 1; zc_det = 0; pwm_lvl = 2'b01;
    tick(SETTLE);
  endtask

  initial begin
    rst_n = 0; drv_en = 1; fault_lat = 0; skip_n = 1; zc_det = 0; pwm_lvl = 2'b01;
    tick(3);
    check("R1 reset", 0, 0);
    rst_n = 1;
    tick(DT);     check("R1 dead after reset", 0, 0);
    tick(1);      check("R1 first turn-on", 1, 0);

    // Sweep of settled behaviour (R2 R3 R4 R8 R9 R11)
    for (int e = 0; e < 2; e++)
      for (int f = 0; f < 2; f++)
        for (int s = 0; s < 2; s++)
          for (int l = 0; l < 4; l++)
            for (int z = 0; z < 2; z++) begin
              logic eh, el;
              string rq;
              settle_hi();
              drv_en = e[0]; fault_lat = f[0]; skip_n = s[0];
              pwm_lvl = l[1:0]; zc_det = z[0];
              tick(SETTLE);
              if (e == 0)      begin eh = 0; el = 0; rq = "R2 sweep"; end
              else if (f == 1) begin eh = 0; el = 0; rq = "R3 sweep"; end
              else if (l == 1) begin eh = 1; el = 0; rq = "R4 sweep high"; end
              else if (l >= 2) begin eh = 0; el = 1; rq = "R8 sweep mid"; end
              else if (s == 1) begin eh = 0; el = 1; rq = "R11 sweep forced"; end
              else begin eh = 0; el = (z == 0); rq = "R9 sweep skip"; end
              check(rq, eh, el);
            end

    // R6: high-side turn-off timing
    settle_hi();
    pwm_lvl = 2'b00;
    tick(HOF);    check("R6 hi held", 1, 0);
    tick(1);      check("R6 hi off", 0, 0);
    tick(DT - 1); check("R6 dead", 0, 0);
    tick(1);      check("R6 lo on", 0, 1);

    // R7: low-side turn-off timing
    pwm_lvl = 2'b01;
    tick(LOF);    check("R7 lo held", 0, 1);
    tick(1);      check("R7 lo off", 0, 0);
    tick(DT - 1); check("R7 dead", 0, 0);
    tick(1);      check("R7 hi on", 1, 0);

    // R8: mid level ignores zero current
    skip_n = 0; zc_det = 1; pwm_lvl = 2'b10;
    tick(HOF + DT + 1); check("R8 mid lo on", 0, 1);
    tick(10);           check("R8 mid zc ignored", 0, 1);

    // R9 / R10: skip cut and its persistence
    zc_det = 0; pwm_lvl = 2'b00;
    tick(3);      check("R9 low before zc", 0, 1);
    zc_det = 1;
    tick(1);      check("R9 zc cut", 0, 0);
    zc_det = 0;
    tick(8);      check("R10 cut held", 0, 0);
    pwm_lvl = 2'b10;
    tick(DT + 1); check("R10 mid overrides", 0, 1);
    pwm_lvl = 2'b00;
    tick(1);      check("R10 cut kept over mid", 0, 0);
    pwm_lvl = 2'b01;
    tick(DT);     check("R10 dead before hi", 0, 0);
    tick(1);      check("R10 hi on", 1, 0);
    pwm_lvl = 2'b00;
    tick(HOF + DT + 1); check("R10 cut cleared by high", 0, 1);

    // R11: forced PWM ignores zero current
    skip_n = 1; zc_det = 1;
    tick(5);      check("R11 forced lo on", 0, 1);

    // R12: short low glitch keeps high side on
    settle_hi();
    pwm_lvl = 2'b00;
    for (int k = 0; k < HOF - 1; k++) begin
      tick(1); check("R12 glitch hi held", 1, 0);
    end
    pwm_lvl = 2'b01;
    for (int k = 0; k < SETTLE; k++) begin
      tick(1); check("R12 no gap", 1, 0);
    end

    // R3: fault and recovery
    fault_lat = 1;
    tick(1);      check("R3 fault off", 0, 0);
    fault_lat = 0;
    tick(DT);     check("R3 dead after fault", 0, 0);
    tick(1);      check("R3 recover", 1, 0);

    // R2: disable and re-enable
    pwm_lvl = 2'b00;
    tick(SETTLE); check("R4 low forced", 0, 1);
    drv_en = 0;
    tick(1);      check("R2 disabled", 0, 0);
    pwm_lvl = 2'b01;
    tick(5);      check("R2 disabled high cmd", 0, 0);
    drv_en = 1;
    tick(DT);     check("R2 dead after enable", 0, 0);
    tick(1);      check("R2 re-enabled", 1, 0);

    vectors++;
    if (overlap_seen != 0) begin
      miscompares++;
      $display("FAIL R5 overlap: got %0d cycles, expected 0", overlap_seen);
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule